// File: doc/BRIEF.md
# Interrupt Request/Acknowledge Sequencer

This block decides when a processor core takes an interrupt and produces the vector number that the execution side needs to enter the handler. It watches two request inputs. The first is a level-sensitive maskable request, gated by the core's interrupt enable flag. The second is a non-maskable input, which is edge-detected and held pending until it is serviced. A decision is taken only on a clock in which the core signals an instruction boundary.

A non-maskable interrupt is handed over at once with the fixed vector 2. It wins over a maskable request that is present at the same boundary. For a maskable interrupt, the block runs an acknowledge handshake on the external bus. The strobe pulses once, stays low for a configurable gap, and then pulses a second time. The requesting device drives its vector byte onto the data input during the second pulse, and the block captures that byte. In both cases the result appears as a one-clock vector-valid pulse with the vector number. The vector table lookup and the saving of state belong to the execution side.

Top module: `irq_ack_seq`

## Requirements
- R1: After reset, `ack_out` and `vec_valid` are low.
- R2: A maskable request presented while `int_enable` is 0 produces no acknowledge pulse and no vector, even across instruction boundaries.
- R3: A maskable request is accepted only on a clock edge at which `insn_boundary` is 1 and the sequencer is idle. `ack_out` goes high in the clock cycle that follows that edge.
- R4: An accepted maskable request drives exactly two `ack_out` pulses, each one clock wide, separated by `ACK_GAP` low clocks. The default `ACK_GAP` is 1.
- R5: The vector is the value of `data_in` during the second acknowledge pulse. It is presented on `vec_num` with `vec_valid` high in the cycle right after that pulse. `data_in` during the first pulse has no effect on the result.
- R6: A rising edge on `nmi_in` is serviced at the next boundary whatever the value of `int_enable`. It produces no acknowledge pulse, and it gives `vec_valid` with `vec_num` = 2 in the cycle after the boundary edge.
- R7: One rising edge on `nmi_in` is serviced exactly once. This holds for a one-clock pulse that arrives while no boundary is present, and also for a level held high over several boundaries.
- R8: When a latched non-maskable request and an enabled maskable request meet at the same boundary, the non-maskable one is serviced first. The maskable one is serviced at a later boundary.
- R9: `vec_valid` is high for a single clock per serviced interrupt.
- R10: A non-maskable edge that arrives during an acknowledge sequence is kept. It is serviced at the first boundary after the sequence ends, and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_req | input | 1 | Maskable interrupt request, level |
| nmi_in | input | 1 | Non-maskable interrupt request, rising edge |
| int_enable | input | 1 | Interrupt enable flag of the core |
| insn_boundary | input | 1 | High for a clock in which the current instruction completes |
| data_in | input | VEC_W | Data bus input that carries the vector byte |
| ack_out | output | 1 | Acknowledge strobe, active high |
| vec_valid | output | 1 | One-clock pulse: `vec_num` holds the vector to service |
| vec_num | output | VEC_W | Vector number handed to the execution side |

## Verification
The hardest case to reach from the ports is a non-maskable edge that lands inside a running acknowledge sequence. It has to be held without disturbing the handshake and without being serviced early. The stimulus starts a maskable acknowledge, pulses `nmi_in` during the low gap between the two strobes, and holds `insn_boundary` low through the rest of the sequence. It then checks that only the maskable vector comes out, and that vector 2 appears only after a later boundary. A second hard case is a non-maskable edge and an enabled maskable request present at the same boundary. The bench builds it by latching a short pulse first and then raising the boundary with the maskable request already asserted.

// File: rtl/irq_seq_pkg.sv
// Package: shared types for the interrupt request/acknowledge sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package irq_seq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ACK1 = 2'd1,
        ST_GAP  = 2'd2,
        ST_ACK2 = 2'd3
    } seq_state_t;
endpackage

// File: rtl/nmi_edge_latch.sv
// Module: nmi_edge_latch
// Detects rising edges of the non-maskable input and holds them pending
// until the sequencer consumes one. A new edge in the same cycle as a
// clear re-arms the latch. Assumes nmi_in is already synchronous to clk.
module nmi_edge_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_in,
    input  logic clear,
    output logic pending
);
    logic prev_q;
    logic pend_q;
    logic rise;

    assign rise    = nmi_in & ~prev_q;
    assign pending = pend_q;

    // Track the previous input level and latch each rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            prev_q <= nmi_in;
            if (rise)
                pend_q <= 1'b1;
            else if (clear)
                pend_q <= 1'b0;
        end
    end

    // R7: the pending flag only sets after the input was seen high.
    a_r7_pend_from_input: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !$past(pend_q)) |-> $past(nmi_in));
endmodule

// File: rtl/irq_arbiter.sv
// Module: irq_arbiter
// Picks what the sequencer starts at an instruction boundary. The
// non-maskable request wins, and the maskable one needs the enable flag.
// Assumes the sequencer reports idle only when it can accept a start.
module irq_arbiter (
    input  logic nmi_pend,
    input  logic irq_req,
    input  logic int_enable,
    input  logic insn_boundary,
    input  logic seq_idle,
    output logic take_nmi,
    output logic take_mask
);
    logic window;

    // Decide the start request for this cycle.
    always_comb begin
        window    = insn_boundary & seq_idle;
        take_nmi  = window & nmi_pend;
        take_mask = window & ~nmi_pend & irq_req & int_enable;
    end
endmodule

// File: rtl/ack_sequencer.sv
// Module: ack_sequencer
// Runs the two-pulse acknowledge handshake for maskable requests and
// issues the vector pulse for both kinds of request. Assumes ACK_GAP >= 1
// and that take_nmi and take_mask are never high together.
module ack_sequencer
    import irq_seq_pkg::*;
#(
    parameter int VEC_W   = 8,
    parameter int NMI_VEC = 2,
    parameter int ACK_GAP = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take_nmi,
    input  logic             take_mask,
    input  logic [VEC_W-1:0] data_in,
    output logic             ack_out,
    output logic             vec_valid,
    output logic [VEC_W-1:0] vec_num,
    output logic             seq_idle
);
    localparam int CW = (ACK_GAP > 1) ? $clog2(ACK_GAP) : 1;
    localparam logic [CW-1:0] GAP_LAST = CW'(ACK_GAP - 1);

    seq_state_t       state_q;
    logic [CW-1:0]    gap_q;
    logic             vld_q;
    logic [VEC_W-1:0] vec_q;

    assign ack_out   = (state_q == ST_ACK1) || (state_q == ST_ACK2);
    assign seq_idle  = (state_q == ST_IDLE);
    assign vec_valid = vld_q;
    assign vec_num   = vec_q;

    // Step the handshake state and produce the vector pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            gap_q   <= '0;
            vld_q   <= 1'b0;
            vec_q   <= '0;
        end else begin
            vld_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (take_nmi) begin
                        vld_q <= 1'b1;
                        vec_q <= VEC_W'(NMI_VEC);
                    end else if (take_mask) begin
                        state_q <= ST_ACK1;
                    end
                end
                ST_ACK1: begin
                    state_q <= ST_GAP;
                    gap_q   <= GAP_LAST;
                end
                ST_GAP: begin
                    if (gap_q == '0)
                        state_q <= ST_ACK2;
                    else
                        gap_q <= gap_q - 1'b1;
                end
                ST_ACK2: begin
                    state_q <= ST_IDLE;
                    vld_q   <= 1'b1;
                    vec_q   <= data_in;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R4: every acknowledge pulse is exactly one clock wide.
    a_r4_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
        ack_out |=> !ack_out);

    // R5: a vector that follows a strobe is the bus byte seen during it.
    a_r5_vec_from_bus: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid && $past(ack_out)) |-> (vec_num == $past(data_in)));

    // R6: a vector without a preceding strobe is the fixed one.
    a_r6_nmi_vector: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid && !$past(ack_out)) |-> (vec_num == VEC_W'(NMI_VEC)));
endmodule

// File: rtl/irq_ack_seq.sv
// Module: irq_ack_seq (top)
// Samples maskable and non-maskable interrupt requests, services them at
// instruction boundaries, runs the acknowledge handshake that fetches a
// maskable vector from the bus, and emits the vector with a valid pulse.
// Assumes all inputs are synchronous to clk.
module irq_ack_seq #(
    parameter int VEC_W   = 8,
    parameter int NMI_VEC = 2,
    parameter int ACK_GAP = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             irq_req,
    input  logic             nmi_in,
    input  logic             int_enable,
    input  logic             insn_boundary,
    input  logic [VEC_W-1:0] data_in,
    output logic             ack_out,
    output logic             vec_valid,
    output logic [VEC_W-1:0] vec_num
);
    logic nmi_pend;
    logic take_nmi;
    logic take_mask;
    logic seq_idle;

    nmi_edge_latch u_nmi (
        .clk     (clk),
        .rst_n   (rst_n),
        .nmi_in  (nmi_in),
        .clear   (take_nmi),
        .pending (nmi_pend)
    );

    irq_arbiter u_arb (
        .nmi_pend      (nmi_pend),
        .irq_req       (irq_req),
        .int_enable    (int_enable),
        .insn_boundary (insn_boundary),
        .seq_idle      (seq_idle),
        .take_nmi      (take_nmi),
        .take_mask     (take_mask)
    );

    ack_sequencer #(
        .VEC_W   (VEC_W),
        .NMI_VEC (NMI_VEC),
        .ACK_GAP (ACK_GAP)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .take_nmi  (take_nmi),
        .take_mask (take_mask),
        .data_in   (data_in),
        .ack_out   (ack_out),
        .vec_valid (vec_valid),
        .vec_num   (vec_num),
        .seq_idle  (seq_idle)
    );

    // R2: with the flag clear, an idle sequencer never starts a strobe.
    a_r2_masked_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_idle && !int_enable) |=> !ack_out);

    // R3: no strobe and no vector without a boundary.
    a_r3_boundary_only: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_idle && !insn_boundary) |=> (!ack_out && !vec_valid));

    // R8: a latched NMI at an idle boundary is serviced before anything else.
    a_r8_nmi_first: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_idle && insn_boundary && nmi_pend) |=> (vec_valid && !ack_out));
endmodule

// File: tb/irq_ack_seq_tb.sv
// Bench: directed scenarios for irq_ack_seq, one task per scenario.
module irq_ack_seq_tb_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       irq_req;
    logic       nmi_in;
    logic       int_enable;
    logic       insn_boundary;
    logic [7:0] data_in;
    logic       ack_out;
    logic       vec_valid;
    logic [7:0] vec_num;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    irq_ack_seq dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .irq_req       (irq_req),
        .nmi_in        (nmi_in),
        .int_enable    (int_enable),
        .insn_boundary (insn_boundary),
        .data_in       (data_in),
        .ack_out       (ack_out),
        .vec_valid     (vec_valid),
        .vec_num       (vec_num)
    );

    always #5 clk = ~clk;

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            fails = fails + 1;
            $display("FAIL watchdog: actual %0d cycles expected < 20000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            fails = fails + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    // R1: outputs after reset.
    task automatic t_reset();
        rst_n = 1'b0; irq_req = 0; nmi_in = 0; int_enable = 0;
        insn_boundary = 0; data_in = 8'h00;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        chk("R1 ack", int'(ack_out), 0);
        chk("R1 valid", int'(vec_valid), 0);
    endtask

    // R2: a masked request never acknowledges.
    task automatic t_masked();
        int seen = 0;
        irq_req = 1; int_enable = 0; insn_boundary = 1;
        for (int i = 0; i < 6; i++) begin
            step();
            seen += int'(ack_out) + int'(vec_valid);
        end
        chk("R2 no ack or vector", seen, 0);
        irq_req = 0; insn_boundary = 0;
        step();
    endtask

    // R3..R5, R9: full maskable handshake; boundary already driven by caller or here.
    task automatic run_mask(input logic [7:0] vec, input string tag);
        irq_req = 1; int_enable = 1; insn_boundary = 1;
        step();
        chk({tag, " R3 first strobe"}, int'(ack_out), 1);
        chk({tag, " R9 no vector yet"}, int'(vec_valid), 0);
        insn_boundary = 0; data_in = ~vec;
        step();
        chk({tag, " R4 gap low"}, int'(ack_out), 0);
        data_in = vec;
        step();
        chk({tag, " R4 second strobe"}, int'(ack_out), 1);
        irq_req = 0;
        step();
        data_in = 8'h00;
        chk({tag, " R4 strobe done"}, int'(ack_out), 0);
        chk({tag, " R5 valid"}, int'(vec_valid), 1);
        chk({tag, " R5 vector"}, int'(vec_num), int'(vec));
        step();
        chk({tag, " R9 single valid"}, int'(vec_valid), 0);
    endtask

    // R3: request held with no boundary, then accepted.
    task automatic t_boundary();
        int seen = 0;
        irq_req = 1; int_enable = 1; insn_boundary = 0;
        for (int i = 0; i < 5; i++) begin
            step();
            seen += int'(ack_out);
        end
        chk("R3 no ack without boundary", seen, 0);
        run_mask(8'h47, "mask47");
    endtask

    // R6, R7: short NMI pulse with flag clear, serviced once.
    task automatic t_nmi_pulse();
        int seen = 0;
        int_enable = 0; insn_boundary = 0;
        nmi_in = 1; step(); nmi_in = 0;
        for (int i = 0; i < 3; i++) begin
            step();
            seen += int'(vec_valid);
        end
        chk("R6 wait for boundary", seen, 0);
        insn_boundary = 1;
        step();
        insn_boundary = 0;
        chk("R6 valid", int'(vec_valid), 1);
        chk("R6 vector 2", int'(vec_num), 2);
        chk("R6 no strobe", int'(ack_out), 0);
        seen = 0;
        insn_boundary = 1;
        for (int i = 0; i < 4; i++) begin
            step();
            seen += int'(vec_valid);
        end
        insn_boundary = 0;
        chk("R7 pulse serviced once", seen, 0);
    endtask

    // R7: NMI level held across boundaries gives one service.
    task automatic t_nmi_level();
        int seen = 0;
        nmi_in = 1; insn_boundary = 1;
        for (int i = 0; i < 6; i++) begin
            step();
            seen += int'(vec_valid);
        end
        nmi_in = 0; insn_boundary = 0;
        step();
        chk("R7 level serviced once", seen, 1);
    endtask

    // R8: NMI and maskable at the same boundary.
    task automatic t_priority();
        insn_boundary = 0;
        nmi_in = 1; step(); nmi_in = 0;
        irq_req = 1; int_enable = 1;
        step();
        insn_boundary = 1;
        step();
        chk("R8 NMI first valid", int'(vec_valid), 1);
        chk("R8 NMI first vector", int'(vec_num), 2);
        chk("R8 no strobe yet", int'(ack_out), 0);
        run_mask(8'h91, "prio91");
    endtask

    // R10: NMI edge during the handshake gap.
    task automatic t_nmi_during_ack();
        int seen = 0;
        irq_req = 1; int_enable = 1; insn_boundary = 1;
        step();
        chk("R10 strobe started", int'(ack_out), 1);
        insn_boundary = 0; nmi_in = 1;
        step();
        nmi_in = 0; data_in = 8'h3C;
        step();
        chk("R10 second strobe", int'(ack_out), 1);
        irq_req = 0;
        step();
        chk("R10 mask vector", int'(vec_num), 8'h3C);
        chk("R10 mask valid", int'(vec_valid), 1);
        for (int i = 0; i < 3; i++) begin
            step();
            seen += int'(vec_valid);
        end
        chk("R10 held until boundary", seen, 0);
        insn_boundary = 1;
        step();
        insn_boundary = 0;
        chk("R10 NMI valid", int'(vec_valid), 1);
        chk("R10 NMI vector", int'(vec_num), 2);
    endtask

    initial begin
        t_reset();
        t_masked();
        t_boundary();
        t_nmi_pulse();
        t_nmi_level();
        t_priority();
        t_nmi_during_ack();
        repeat (2) step();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule